// File: doc/BRIEF.md
# Accumulator ALU with Pointer-Pair Carry Extension

This block is the arithmetic and logic stage of an 8-bit accumulator machine. Each cycle it takes the accumulator W, a register operand (or literal), the current status byte, the destination register address, a direction bit and an operation code. One clock edge later it presents the result byte, destination write strobes, the updated status byte, a multiply high byte and a skip request. The register file itself lives elsewhere: the block only computes values and says where they go.

Subtraction is register minus W, and carry means "no borrow". When an add, subtract, increment or decrement writes back to the low byte of one of the pointer pairs, the operation widens to 16 bits. The register one address below supplies the high byte, and a second result byte is produced for it.

Top module: `acc_alu8`

## Requirements
- R1: ADD gives register + W and ADDC gives register + W + C. C (status bit 0) is the carry out of bit 7. DC (status bit 1) is the carry out of bit 3. Z (status bit 2) is set when the result byte is zero.
- R2: SUB gives register - W and SUBC gives register - W - (1 - C). C is set when no borrow occurs, DC is set when no nibble borrow occurs, and Z follows the result. With a literal operand and the W destination, this writes literal - W into W.
- R3: CMP updates C, DC and Z exactly as SUB would, raises neither write strobe and does not request a skip.
- R4: AND, OR, XOR, NOT (inverted operand), INC, DEC, TEST (operand only), CLR (zero) and MOVW (operand into W) update only Z.
- R5: RL moves old C into bit 0 and bit 7 into C. RR moves old C into bit 7 and bit 0 into C. SWAP exchanges the nibbles and leaves all flags unchanged.
- R6: MULU and MULS write the low product byte to W and the high byte to the multiply output, with its strobe raised. MULS sign-extends W. It sign-extends a register operand but zero-extends a literal operand.
- R7: Pair mode applies when the direction bit selects the register and the operation is ADD, ADDC, SUB, SUBC, INC, DEC, INCSZ, INCSNZ, DECSZ or DECSNZ, and the address is 0x005, 0x007, 0x009, 0x00D or 0x011. The value {high operand, operand} is then operated on at 16 bits and the high result strobe is raised. In every other case that strobe stays low.
- R8: In pair mode, C and DC come from the low-byte operation alone, and Z and the skip decision reflect only the low result byte.
- R9: INCSZ and DECSZ request a skip on a zero result. INCSNZ and DECSNZ request a skip on a nonzero result. None of these four changes any flag. CSE requests a skip when W equals the operand, and CSNE requests one when they differ.
- R10: Status bits 7..3, and any flag an operation does not define, pass through from the status input unchanged.
- R11: The W strobe rises when the direction bit is 1, and for multiplies and MOVW. Otherwise the register strobe rises. CMP, TEST, CSE and CSNE raise neither strobe.
- R12: All outputs are registered with one cycle of latency and read zero during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 5 | Operation code (package enumeration) |
| to_w_i | input | 1 | 1: result to W, 0: result to register |
| lit_i | input | 1 | Operand is a literal |
| w_i | input | 8 | Accumulator W |
| opnd_i | input | 8 | Register operand or literal |
| opnd_hi_i | input | 8 | Register one address below the destination |
| addr_i | input | 9 | Destination register address |
| status_i | input | 8 | Current status byte |
| result_o | output | 8 | Result byte |
| result_hi_o | output | 8 | High result byte in pair mode, else zero |
| wr_w_o | output | 1 | Write result into W |
| wr_reg_o | output | 1 | Write result into register |
| wr_hi_o | output | 1 | Write high result at address - 1 |
| status_o | output | 8 | Updated status byte |
| mulh_o | output | 8 | Multiply high byte |
| mulh_we_o | output | 1 | Multiply high byte valid |
| skip_o | output | 1 | Skip next instruction |

## Verification
The bench builds the block with its defaults: 8-bit data and 9-bit addresses. At that width, exhaustive-style random operands reach every carry, nibble-carry and sign boundary in a few thousand operations. The nine-bit address lets the random mix land on each of the five pair addresses as well as their neighbours 0x004, 0x006 and 0x010, so both sides of the pair decision are exercised.

// File: rtl/acc_alu8_pkg.sv
package acc_alu8_pkg;

  typedef enum logic [4:0] {
    ALU_ADD, ALU_ADDC, ALU_SUB, ALU_SUBC, ALU_CMP,
    ALU_AND, ALU_OR, ALU_XOR, ALU_NOT,
    ALU_INC, ALU_DEC, ALU_INCSZ, ALU_INCSNZ, ALU_DECSZ, ALU_DECSNZ,
    ALU_RL, ALU_RR, ALU_SWAP, ALU_MULU, ALU_MULS,
    ALU_TEST, ALU_CLR, ALU_MOVW, ALU_CSE, ALU_CSNE
  } alu_op_e;

  localparam int FLG_C  = 0;
  localparam int FLG_DC = 1;
  localparam int FLG_Z  = 2;

  // low byte of a pointer pair; the high byte sits one address lower
  function automatic logic is_pair_low(input logic [15:0] a);
    return (a == 16'h0005) || (a == 16'h0007) || (a == 16'h0009) ||
           (a == 16'h000D) || (a == 16'h0011);
  endfunction

  function automatic logic uses_adder(input alu_op_e op);
    return op inside {ALU_ADD, ALU_ADDC, ALU_SUB, ALU_SUBC, ALU_CMP,
                      ALU_INC, ALU_DEC, ALU_INCSZ, ALU_INCSNZ,
                      ALU_DECSZ, ALU_DECSNZ};
  endfunction

  function automatic logic pair_capable(input alu_op_e op);
    return uses_adder(op) && (op != ALU_CMP);
  endfunction

endpackage

// File: rtl/acc_alu8_addsub.sv
module acc_alu8_addsub #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  input  logic [DW-1:0] hi_i,
  input  logic [DW-1:0] hi_ext_i,
  output logic [DW-1:0] sum_o,
  output logic [DW-1:0] sum_hi_o,
  output logic          c_o,
  output logic          dc_o
);
  localparam int HW = DW / 2;

  logic [DW:0] full;

  assign full     = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, cin_i};
  assign sum_o    = full[DW-1:0];
  assign c_o      = full[DW];
  // carry into the upper nibble recovered from the sum bit
  assign dc_o     = a_i[HW] ^ b_i[HW] ^ full[HW];
  assign sum_hi_o = hi_i + hi_ext_i + {{(DW-1){1'b0}}, full[DW]};

endmodule

// File: rtl/acc_alu8_misc.sv
module acc_alu8_misc
  import acc_alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] w_i,
  input  logic          cin_i,
  input  logic          lit_i,
  output logic [DW-1:0] res_o,
  output logic          c_o,
  output logic [DW-1:0] mulh_o
);
  localparam int HW = DW / 2;
  localparam int PW = 2 * DW;

  logic [PW-1:0] w_sx, a_x, w_zx, a_zx, prod_s, prod_u, prod;

  assign w_sx   = {{DW{w_i[DW-1]}}, w_i};
  assign a_x    = lit_i ? {{DW{1'b0}}, a_i} : {{DW{a_i[DW-1]}}, a_i};
  assign w_zx   = {{DW{1'b0}}, w_i};
  assign a_zx   = {{DW{1'b0}}, a_i};
  assign prod_s = w_sx * a_x;
  assign prod_u = w_zx * a_zx;
  assign prod   = (op_i == ALU_MULS) ? prod_s : prod_u;
  assign mulh_o = prod[PW-1:DW];

  always_comb begin
    c_o   = cin_i;
    res_o = a_i;
    case (op_i)
      ALU_AND:  res_o = a_i & w_i;
      ALU_OR:   res_o = a_i | w_i;
      ALU_XOR:  res_o = a_i ^ w_i;
      ALU_NOT:  res_o = ~a_i;
      ALU_CLR:  res_o = '0;
      ALU_SWAP: res_o = {a_i[HW-1:0], a_i[DW-1:HW]};
      ALU_RL: begin
        res_o = {a_i[DW-2:0], cin_i};
        c_o   = a_i[DW-1];
      end
      ALU_RR: begin
        res_o = {cin_i, a_i[DW-1:1]};
        c_o   = a_i[0];
      end
      ALU_MULU, ALU_MULS: res_o = prod[DW-1:0];
      default: res_o = a_i;
    endcase
  end

endmodule

// File: rtl/acc_alu8.sv
module acc_alu8
  import acc_alu8_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        op_i,
  input  logic              to_w_i,
  input  logic              lit_i,
  input  logic [DATA_W-1:0] w_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [DATA_W-1:0] opnd_hi_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        status_i,
  output logic [DATA_W-1:0] result_o,
  output logic [DATA_W-1:0] result_hi_o,
  output logic              wr_w_o,
  output logic              wr_reg_o,
  output logic              wr_hi_o,
  output logic [7:0]        status_o,
  output logic [DATA_W-1:0] mulh_o,
  output logic              mulh_we_o,
  output logic              skip_o
);
  localparam int DW = DATA_W;

  alu_op_e       op;
  logic          c_in, pair;
  logic [DW-1:0] b_sel, hx_sel;
  logic          cin_sel;
  logic [DW-1:0] as_sum, as_hi, mx_res, mx_mulh, lo;
  logic          as_c, as_dc, mx_c, zero_lo, writes, to_w_eff;

  logic [DW-1:0] n_res, n_hi, n_mulh;
  logic [7:0]    n_status;
  logic          n_wr_w, n_wr_reg, n_wr_hi, n_mulh_we, n_skip;
  logic          primed_q;

  assign op   = alu_op_e'(op_i);
  assign c_in = status_i[FLG_C];
  assign pair = !to_w_i && pair_capable(op) &&
                is_pair_low(16'(addr_i));

  // second operand, carry-in and high-byte extension for the adder
  always_comb begin
    b_sel   = w_i;
    cin_sel = 1'b0;
    hx_sel  = '0;
    case (op)
      ALU_ADDC: cin_sel = c_in;
      ALU_SUB, ALU_CMP: begin
        b_sel = ~w_i; cin_sel = 1'b1; hx_sel = '1;
      end
      ALU_SUBC: begin
        b_sel = ~w_i; cin_sel = c_in; hx_sel = '1;
      end
      ALU_INC, ALU_INCSZ, ALU_INCSNZ: b_sel = {{(DW-1){1'b0}}, 1'b1};
      ALU_DEC, ALU_DECSZ, ALU_DECSNZ: begin
        b_sel = '1; hx_sel = '1;
      end
      default: ;
    endcase
  end

  acc_alu8_addsub #(.DW(DW)) u_addsub (
    .a_i(opnd_i), .b_i(b_sel), .cin_i(cin_sel),
    .hi_i(opnd_hi_i), .hi_ext_i(hx_sel),
    .sum_o(as_sum), .sum_hi_o(as_hi), .c_o(as_c), .dc_o(as_dc)
  );

  acc_alu8_misc #(.DW(DW)) u_misc (
    .op_i(op), .a_i(opnd_i), .w_i(w_i), .cin_i(c_in), .lit_i(lit_i),
    .res_o(mx_res), .c_o(mx_c), .mulh_o(mx_mulh)
  );

  assign lo       = uses_adder(op) ? as_sum : mx_res;
  assign zero_lo  = (lo == '0);
  assign writes   = !(op inside {ALU_CMP, ALU_TEST, ALU_CSE, ALU_CSNE});
  assign to_w_eff = to_w_i || (op inside {ALU_MULU, ALU_MULS, ALU_MOVW});

  // next-state logic
  always_comb begin
    n_status  = status_i;
    n_skip    = 1'b0;
    n_res     = lo;
    n_hi      = pair ? as_hi : '0;
    n_wr_hi   = pair;
    n_wr_w    = writes && to_w_eff;
    n_wr_reg  = writes && !to_w_eff;
    n_mulh_we = (op == ALU_MULU) || (op == ALU_MULS);
    n_mulh    = n_mulh_we ? mx_mulh : '0;
    case (op)
      ALU_ADD, ALU_ADDC, ALU_SUB, ALU_SUBC, ALU_CMP: begin
        n_status[FLG_C]  = as_c;
        n_status[FLG_DC] = as_dc;
        n_status[FLG_Z]  = zero_lo;
      end
      ALU_AND, ALU_OR, ALU_XOR, ALU_NOT, ALU_INC, ALU_DEC,
      ALU_TEST, ALU_CLR, ALU_MOVW: n_status[FLG_Z] = zero_lo;
      ALU_RL, ALU_RR:              n_status[FLG_C] = mx_c;
      ALU_INCSZ, ALU_DECSZ:        n_skip = zero_lo;
      ALU_INCSNZ, ALU_DECSNZ:      n_skip = !zero_lo;
      ALU_CSE:                     n_skip = (w_i == opnd_i);
      ALU_CSNE:                    n_skip = (w_i != opnd_i);
      default: ;
    endcase
  end

  // output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o    <= '0;
      result_hi_o <= '0;
      wr_w_o      <= 1'b0;
      wr_reg_o    <= 1'b0;
      wr_hi_o     <= 1'b0;
      status_o    <= '0;
      mulh_o      <= '0;
      mulh_we_o   <= 1'b0;
      skip_o      <= 1'b0;
      primed_q    <= 1'b0;
    end else begin
      result_o    <= n_res;
      result_hi_o <= n_hi;
      wr_w_o      <= n_wr_w;
      wr_reg_o    <= n_wr_reg;
      wr_hi_o     <= n_wr_hi;
      status_o    <= n_status;
      mulh_o      <= n_mulh;
      mulh_we_o   <= n_mulh_we;
      skip_o      <= n_skip;
      primed_q    <= 1'b1;
    end
  end

  assert_one_dest_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_w_o, wr_reg_o}));

  assert_pair_to_reg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi_o |-> (wr_reg_o && !wr_w_o));

  assert_mulh_to_w_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mulh_we_o |-> (wr_w_o && !wr_reg_o));

  assert_upper_hold_R10: assert property (@(posedge clk)
    disable iff (!rst_n || !primed_q)
    status_o[7:3] == $past(status_i[7:3]));

  assert_cmp_silent_R3: assert property (@(posedge clk)
    disable iff (!rst_n || !primed_q)
    ($past(op_i) == 5'(ALU_CMP)) |-> (!wr_w_o && !wr_reg_o && !skip_o));

  assert_cse_skip_R9: assert property (@(posedge clk)
    disable iff (!rst_n || !primed_q)
    ($past(op_i) == 5'(ALU_CSE)) |-> (skip_o == ($past(w_i) == $past(opnd_i))));

  assert_rl_carry_R5: assert property (@(posedge clk)
    disable iff (!rst_n || !primed_q)
    ($past(op_i) == 5'(ALU_RL)) |->
      ((status_o[FLG_C] == $past(opnd_i[DW-1])) &&
       (result_o[0] == $past(status_i[FLG_C]))));

endmodule

// File: tb/test_acc_alu8.sv
module test_acc_alu8;
  import acc_alu8_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] op_i = '0;
  logic       to_w_i = 1'b0, lit_i = 1'b0;
  logic [7:0] w_i = '0, opnd_i = '0, opnd_hi_i = '0, status_i = '0;
  logic [8:0] addr_i = '0;
  logic [7:0] result_o, result_hi_o, status_o, mulh_o;
  logic       wr_w_o, wr_reg_o, wr_hi_o, mulh_we_o, skip_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_alu8 i_acc_alu8 (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .to_w_i(to_w_i), .lit_i(lit_i),
    .w_i(w_i), .opnd_i(opnd_i), .opnd_hi_i(opnd_hi_i), .addr_i(addr_i),
    .status_i(status_i), .result_o(result_o), .result_hi_o(result_hi_o),
    .wr_w_o(wr_w_o), .wr_reg_o(wr_reg_o), .wr_hi_o(wr_hi_o),
    .status_o(status_o), .mulh_o(mulh_o), .mulh_we_o(mulh_we_o),
    .skip_o(skip_o)
  );

  function automatic string req_of(input int op);
    case (op)
      ALU_ADD, ALU_ADDC:                         return "R1";
      ALU_SUB, ALU_SUBC:                         return "R2";
      ALU_CMP:                                   return "R3";
      ALU_RL, ALU_RR, ALU_SWAP:                  return "R5";
      ALU_MULU, ALU_MULS:                        return "R6";
      ALU_INCSZ, ALU_INCSNZ, ALU_DECSZ,
      ALU_DECSNZ, ALU_CSE, ALU_CSNE:             return "R9";
      default:                                   return "R4";
    endcase
  endfunction

  // expected: {res, hi, status, mulh, skip, wr_w, wr_reg, wr_hi, mulh_we}
  function automatic logic [36:0] model(input int op, input bit tw, input bit lit,
      input int w, input int r, input int hi, input int addr, input logic [7:0] st);
    int t, v, cin, ws, rs, p;
    logic [7:0] s, res, rh, mh;
    bit skp, ww, wr, hwe, mwe, pr, wrt, dst_w;
    s = st; res = 8'(r); rh = 0; mh = 0; skp = 0; hwe = 0; mwe = 0;
    cin = st[0];
    pr = !tw && (addr == 5 || addr == 7 || addr == 9 || addr == 13 || addr == 17) &&
         (op inside {ALU_ADD, ALU_ADDC, ALU_SUB, ALU_SUBC, ALU_INC, ALU_DEC,
                     ALU_INCSZ, ALU_INCSNZ, ALU_DECSZ, ALU_DECSNZ});
    v = hi * 256 + r;
    case (op)
      ALU_ADD, ALU_ADDC: begin
        if (op == ALU_ADD) cin = 0;
        t = r + w + cin;
        res = 8'(t); s[0] = t > 255; s[1] = ((r % 16) + (w % 16) + cin) > 15;
        s[2] = (res == 0); v = v + w + cin;
      end
      ALU_SUB, ALU_SUBC, ALU_CMP: begin
        cin = (op == ALU_SUBC) ? 1 - st[0] : 0;
        t = r - w - cin;
        res = 8'(t); s[0] = t >= 0; s[1] = ((r % 16) - (w % 16) - cin) >= 0;
        s[2] = (res == 0); v = v - w - cin;
      end
      ALU_AND:  begin res = 8'(r & w); s[2] = res == 0; end
      ALU_OR:   begin res = 8'(r | w); s[2] = res == 0; end
      ALU_XOR:  begin res = 8'(r ^ w); s[2] = res == 0; end
      ALU_NOT:  begin res = 8'(255 - r); s[2] = res == 0; end
      ALU_TEST, ALU_MOVW: s[2] = (r == 0);
      ALU_CLR:  begin res = 0; s[2] = 1; end
      ALU_INC, ALU_INCSZ, ALU_INCSNZ: begin
        res = 8'(r + 1); v = v + 1;
        if (op == ALU_INC) s[2] = res == 0;
        if (op == ALU_INCSZ) skp = res == 0;
        if (op == ALU_INCSNZ) skp = res != 0;
      end
      ALU_DEC, ALU_DECSZ, ALU_DECSNZ: begin
        res = 8'(r + 255); v = v + 65535;
        if (op == ALU_DEC) s[2] = res == 0;
        if (op == ALU_DECSZ) skp = res == 0;
        if (op == ALU_DECSNZ) skp = res != 0;
      end
      ALU_RL:   begin res = 8'(r * 2 + cin); s[0] = r >= 128; end
      ALU_RR:   begin res = 8'(r / 2 + cin * 128); s[0] = r % 2; end
      ALU_SWAP: res = 8'((r % 16) * 16 + r / 16);
      ALU_MULU, ALU_MULS: begin
        ws = w; rs = r;
        if (op == ALU_MULS) begin
          if (w >= 128) ws = w - 256;
          if (!lit && r >= 128) rs = r - 256;
        end
        p = ws * rs;
        res = 8'(p); mh = 8'(p >>> 8); mwe = 1;
      end
      ALU_CSE:  skp = (w == r);
      ALU_CSNE: skp = (w != r);
      default: ;
    endcase
    if (pr) begin hwe = 1; rh = 8'(v >>> 8); end
    wrt   = !(op inside {ALU_CMP, ALU_TEST, ALU_CSE, ALU_CSNE});
    dst_w = tw || op inside {ALU_MULU, ALU_MULS, ALU_MOVW};
    ww = wrt && dst_w; wr = wrt && !dst_w;
    return {res, rh, s, mh, skp, ww, wr, hwe, mwe};
  endfunction

  task automatic run(input int op, input bit tw, input bit lit, input int w,
      input int r, input int hi, input int addr, input logic [7:0] st,
      input string tag);
    logic [36:0] e, g;
    op_i = 5'(op); to_w_i = tw; lit_i = lit; w_i = 8'(w); opnd_i = 8'(r);
    opnd_hi_i = 8'(hi); addr_i = 9'(addr); status_i = st;
    e = model(op, tw, lit, w, r, hi, addr, st);
    @(negedge clk);
    g = {result_o, result_hi_o, status_o, mulh_o, skip_o, wr_w_o, wr_reg_o,
         wr_hi_o, mulh_we_o};
    // compare only the bytes whose strobe is raised
    if (!(e[3] || e[2])) begin e[36:29] = '0; g[36:29] = '0; end
    if (!e[1]) begin e[28:21] = '0; g[28:21] = '0; end
    if (!e[0]) begin e[12:5] = '0; g[12:5] = '0; end
    checks++;
    if (g !== e) begin
      errors++;
      $display("FAIL %s op=%0d got=%h exp=%h", tag, op, g, e);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    checks++;   // R12 reset state
    if ({result_o, result_hi_o, status_o, mulh_o, skip_o, wr_w_o, wr_reg_o,
         wr_hi_o, mulh_we_o} !== '0) begin
      errors++;
      $display("FAIL R12 reset outputs nonzero got=%h exp=0", result_o);
    end
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    run(ALU_ADD,  1, 0, 8'hFF, 8'h01, 0, 0, 8'h00, "R1");
    run(ALU_ADDC, 0, 0, 8'h0F, 8'h00, 0, 3, 8'h01, "R1");
    run(ALU_SUB,  0, 0, 8'h01, 8'h10, 0, 3, 8'h00, "R2");
    run(ALU_SUBC, 0, 0, 8'h05, 8'h05, 0, 3, 8'h00, "R2");
    run(ALU_SUB,  1, 1, 8'h30, 8'h20, 0, 0, 8'h00, "R2");
    run(ALU_CMP,  0, 0, 8'h44, 8'h44, 0, 9, 8'h00, "R3");
    run(ALU_CLR,  0, 0, 8'h44, 8'h9A, 0, 3, 8'hF8, "R4");
    run(ALU_RL,   0, 0, 0, 8'h80, 0, 3, 8'h01, "R5");
    run(ALU_RR,   1, 0, 0, 8'h01, 0, 3, 8'h00, "R5");
    run(ALU_SWAP, 0, 0, 0, 8'hA5, 0, 3, 8'h07, "R5");
    run(ALU_MULS, 1, 1, 8'hFF, 8'h80, 0, 0, 8'h00, "R6");
    run(ALU_MULS, 1, 0, 8'hFF, 8'h80, 0, 0, 8'h00, "R6");
    run(ALU_MULU, 1, 0, 8'hFF, 8'hFF, 0, 0, 8'h00, "R6");
    run(ALU_INC,  0, 0, 0, 8'hFF, 8'h12, 9'h009, 8'h00, "R7");
    run(ALU_DEC,  0, 0, 0, 8'h00, 8'h00, 9'h011, 8'h00, "R7");
    run(ALU_ADD,  0, 0, 8'h01, 8'hFF, 8'h12, 9'h00A, 8'h00, "R7");
    run(ALU_ADD,  1, 0, 8'h01, 8'hFF, 8'h12, 9'h005, 8'h00, "R7");
    run(ALU_SUB,  0, 0, 8'h01, 8'h00, 8'h10, 9'h00D, 8'h00, "R8");
    run(ALU_INCSZ,0, 0, 0, 8'hFF, 8'h00, 9'h007, 8'h04, "R8");
    run(ALU_DECSNZ,0,0, 0, 8'h01, 8'h00, 9'h003, 8'h00, "R9");
    run(ALU_CSE,  0, 0, 8'h3C, 8'h3C, 0, 3, 8'h00, "R9");
    run(ALU_CSNE, 0, 0, 8'h3C, 8'h3C, 0, 3, 8'h00, "R9");
    run(ALU_TEST, 0, 0, 0, 8'h00, 0, 3, 8'hA8, "R10");
    run(ALU_MOVW, 0, 0, 0, 8'h7E, 0, 3, 8'h00, "R11");
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      int op, ad;
      op = int'($urandom_range(0, 24));
      case ($urandom_range(0, 3))
        0: ad = 5 + 2 * int'($urandom_range(0, 2));
        1: ad = ($urandom_range(0, 1) != 0) ? 13 : 17;
        2: ad = int'($urandom_range(4, 18));
        default: ad = int'($urandom_range(0, 511));
      endcase
      run(op, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
          int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
          int'($urandom_range(0, 255)), ad, 8'($urandom), req_of(op));
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule